// File: doc/BRIEF.md
# Serial FIFO Interrupt Status Controller

This block holds the control registers and the interrupt logic of a serial port that pairs a 16550-compatible UART with large external receive and transmit FIFOs. It takes the FIFOs' full, half-full and empty flags, their pop and push strobes, a character-timeout event and a periodic timer tick. It merges five interrupt sources into a single request line. Each source has its own set and clear rule.

Software reaches the block over a small byte-wide register port with a one-cycle write strobe and a combinational read path. Offset 0 holds the configuration byte. Offset 1 holds the per-source enables. Offset 2 returns a status byte when read. A write to offset 2 fires a one-cycle reset strobe toward the external FIFOs. The request line runs in one of two modes, chosen at run time: a level that follows the enabled pending sources, or a one-cycle pulse each time that set goes from none to some.

Top module: `sfis_top`

## Requirements
- R1: After reset, offsets 0 and 1 read 0x00, status bits 7 and 6 read 0, `irq` is low and `fifo_reset` is low.
- R2: Offset 0 stores bit4 (1 = level request, 0 = pulse request), bit3 (drives `flow_ctl_en`), bit2 (drives `ext_fifo_en`) and bit0 (drives `swap_halves`). Bit1 and bits 7..5 ignore writes and read 0, so a write of d reads back d & 0x1D.
- R3: Offset 1 stores the enables: bit0 receive half-full, bit1 transmit half-full, bit2 transmit empty, bit3 character timeout, bit4 timer. Bits 7..5 read 0, so a write of d reads back d & 0x1F.
- R4: Reading offset 2 returns bit7 = timer pending and bit6 = timeout pending, whatever the enables are. Bits 5..0 return the inverse of rx_full, rx_half, rx_empty, tx_full, tx_half and tx_empty in that order, so 0 means the condition holds.
- R5: A write to offset 2 drives `fifo_reset` high in that same cycle and leaves offsets 0 and 1 unchanged. A write to any other offset leaves `fifo_reset` low.
- R6: The receive half-full source is pending exactly while `rx_half` is high. It stays set until reads take the FIFO below half.
- R7: The timeout source sets on `char_tmo`. It clears on `rx_pop` or on a read of offset 2. When a set and a clear come in the same cycle, the set wins.
- R8: The transmit-empty source sets when `tx_empty` rises. It clears on `tx_push` or on a read of offset 2. A flag that stays high does not set it again.
- R9: The transmit half-full source sets when `tx_half` falls. It clears when `tx_half` rises again or on a read of offset 2.
- R10: The timer source sets on `timer_tick`. Reading offset 2 does not clear it. Any write to offset 1 with bit4 = 0 clears it.
- R11: In level mode, `irq` equals the OR over the five sources of pending AND enabled, in the same cycle.
- R12: In pulse mode, `irq` is high for one cycle when that OR rises, and low while the OR stays high.
- R13: Reads of offsets 3 and above return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle, triggers clear-on-read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| rx_full | input | 1 | Receive FIFO full |
| rx_half | input | 1 | Receive FIFO at or above half |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| tx_half | input | 1 | Transmit FIFO at or above half |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_pop | input | 1 | Receive FIFO read strobe |
| tx_push | input | 1 | Transmit FIFO write strobe |
| char_tmo | input | 1 | Character timeout event |
| timer_tick | input | 1 | Timer expiry event |
| fifo_reset | output | 1 | External FIFO reset strobe |
| flow_ctl_en | output | 1 | Automatic RTS/CTS handshake enable |
| ext_fifo_en | output | 1 | External FIFO enable |
| swap_halves | output | 1 | Swap 8-byte halves of the 16-byte window |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default `ADDR_W` of 3. With that width, every offset from 0 to 7 can be reached, including the five unused ones. The byte registers are small enough to sweep all 256 write values, and the status byte is swept over all 64 FIFO flag patterns. With the timer and timeout sources held pending and the receive half-full level set both ways, the level-mode request is checked against every enable word that keeps the timer enabled. The bench also covers each source's set and clear edges, a set and a clear in the same cycle, and a pulse-mode request that stays high.

// File: rtl/sfis_pkg.sv
package sfis_pkg;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned SRC_N   = 5;

   // interrupt source indices, also enable bit positions
   localparam int unsigned SRC_RXH = 0;
   localparam int unsigned SRC_TXH = 1;
   localparam int unsigned SRC_TXE = 2;
   localparam int unsigned SRC_CTO = 3;
   localparam int unsigned SRC_TMR = 4;

   // register offsets
   localparam int unsigned OFS_CFG  = 0;
   localparam int unsigned OFS_IEN  = 1;
   localparam int unsigned OFS_STAT = 2;

   // configuration bit positions
   localparam int unsigned CB_SWAP = 0;
   localparam int unsigned CB_EXTF = 2;
   localparam int unsigned CB_FLOW = 3;
   localparam int unsigned CB_LVL  = 4;

   localparam logic [BYTE_W-1:0] CFG_WMASK = 8'h1D;
   localparam logic [BYTE_W-1:0] IEN_WMASK = 8'h1F;

   typedef struct packed {
      logic rx_full;
      logic rx_half;
      logic rx_empty;
      logic tx_full;
      logic tx_half;
      logic tx_empty;
   } fifo_flags_t;
endpackage

// File: rtl/sfis_regs.sv
module sfis_regs
   import sfis_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic [BYTE_W-1:0] stat_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic [BYTE_W-1:0] cfg_o,
   output logic [BYTE_W-1:0] ien_o,
   output logic              stat_rd_o,
   output logic              fifo_rst_o,
   output logic              tmr_clr_o
);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   logic [BYTE_W-1:0] cfg_q, ien_q;
   logic              hit_cfg, hit_ien, hit_stat;

   assign hit_cfg  = (addr_i == A_CFG);
   assign hit_ien  = (addr_i == A_IEN);
   assign hit_stat = (addr_i == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         ien_q <= '0;
      end else if (wr_i) begin
         if (hit_cfg) cfg_q <= wdata_i & CFG_WMASK;
         if (hit_ien) ien_q <= wdata_i & IEN_WMASK;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_cfg)       rdata_o = cfg_q;
      else if (hit_ien)  rdata_o = ien_q;
      else if (hit_stat) rdata_o = stat_i;
   end

   assign cfg_o      = cfg_q;
   assign ien_o      = ien_q;
   assign stat_rd_o  = rd_i & hit_stat;
   assign fifo_rst_o = wr_i & hit_stat;
   assign tmr_clr_o  = wr_i & hit_ien & ~wdata_i[SRC_TMR];

   // R5: a FIFO reset write touches neither stored register
   p_stat_wr_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && hit_stat) |=> ($stable(cfg_q) && $stable(ien_q)));
endmodule

// File: rtl/sfis_src.sv
module sfis_src #(
   parameter bit STICKY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   generate
      if (STICKY) begin : g_sticky
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend_q <= 1'b0;
            else if (set_i)  pend_q <= 1'b1;
            else if (clr_i)  pend_q <= 1'b0;
         end
         assign pend_o = pend_q;

         // R7 (shared by R8, R9, R10): a set always lands, even against a clear
         p_src_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> pend_o);
         // R7 (shared by R8, R9, R10): a lone clear drops the source
         p_src_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i) |=> !pend_o);
      end else begin : g_level
         assign pend_o = set_i;
      end
   endgenerate
endmodule

// File: rtl/sfis_irq_out.sv
module sfis_irq_out
   import sfis_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_N-1:0] pend_i,
   input  logic [SRC_N-1:0] en_i,
   input  logic             level_i,
   output logic             irq_o
);
   logic any_req, any_q;

   assign any_req = |(pend_i & en_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) any_q <= 1'b0;
      else        any_q <= any_req;
   end

   assign irq_o = level_i ? any_req : (any_req & ~any_q);

   // R12: a pulse-mode request never lasts two cycles
   p_edge_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_i && irq_o) |=> (level_i || !irq_o));
   // R11: the request only rises with an enabled pending source
   p_irq_needs_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|(pend_i & en_i)));
endmodule

// File: rtl/sfis_top.sv
module sfis_top
   import sfis_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rx_full,
   input  logic              rx_half,
   input  logic              rx_empty,
   input  logic              tx_full,
   input  logic              tx_half,
   input  logic              tx_empty,
   input  logic              rx_pop,
   input  logic              tx_push,
   input  logic              char_tmo,
   input  logic              timer_tick,
   output logic              fifo_reset,
   output logic              flow_ctl_en,
   output logic              ext_fifo_en,
   output logic              swap_halves,
   output logic              irq
);
   generate
      if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr_w
         $error("sfis_top: ADDR_W must lie in 2..8");
      end
   endgenerate

   fifo_flags_t       flags;
   logic [BYTE_W-1:0] cfg, ien, stat_byte;
   logic              stat_rd, tmr_clr;
   logic              tx_half_q, tx_empty_q;
   logic [SRC_N-1:0]  src_set, src_clr, pend;

   assign flags = '{rx_full: rx_full, rx_half: rx_half, rx_empty: rx_empty,
                    tx_full: tx_full, tx_half: tx_half, tx_empty: tx_empty};

   assign stat_byte = {pend[SRC_TMR], pend[SRC_CTO], ~flags};

   sfis_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (bus_addr),
      .wr_i      (bus_wr),
      .rd_i      (bus_rd),
      .wdata_i   (bus_wdata),
      .stat_i    (stat_byte),
      .rdata_o   (bus_rdata),
      .cfg_o     (cfg),
      .ien_o     (ien),
      .stat_rd_o (stat_rd),
      .fifo_rst_o(fifo_reset),
      .tmr_clr_o (tmr_clr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_half_q  <= 1'b0;
         tx_empty_q <= 1'b0;
      end else begin
         tx_half_q  <= tx_half;
         tx_empty_q <= tx_empty;
      end
   end

   always_comb begin
      src_set          = '0;
      src_clr          = '0;
      src_set[SRC_RXH] = rx_half;
      src_set[SRC_TXH] = tx_half_q & ~tx_half;
      src_clr[SRC_TXH] = (~tx_half_q & tx_half) | stat_rd;
      src_set[SRC_TXE] = tx_empty & ~tx_empty_q;
      src_clr[SRC_TXE] = tx_push | stat_rd;
      src_set[SRC_CTO] = char_tmo;
      src_clr[SRC_CTO] = rx_pop | stat_rd;
      src_set[SRC_TMR] = timer_tick;
      src_clr[SRC_TMR] = tmr_clr;
   end

   generate
      for (genvar s = 0; s < SRC_N; s++) begin : g_src
         sfis_src #(.STICKY(s != SRC_RXH)) src_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (src_set[s]),
            .clr_i (src_clr[s]),
            .pend_o(pend[s])
         );
      end
   endgenerate

   sfis_irq_out irq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .en_i   (ien[SRC_N-1:0]),
      .level_i(cfg[CB_LVL]),
      .irq_o  (irq)
   );

   assign flow_ctl_en = cfg[CB_FLOW];
   assign ext_fifo_en = cfg[CB_EXTF];
   assign swap_halves = cfg[CB_SWAP];
endmodule

// File: tb/sfis_top_tb_top.sv
module sfis_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_full = 0, rx_half = 0, rx_empty = 0;
   logic       tx_full = 0, tx_half = 0, tx_empty = 0;
   logic       rx_pop = 0, tx_push = 0, char_tmo = 0, timer_tick = 0;
   logic       fifo_reset, flow_ctl_en, ext_fifo_en, swap_halves, irq;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   sfis_top #(.ADDR_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_full(rx_full), .rx_half(rx_half), .rx_empty(rx_empty),
      .tx_full(tx_full), .tx_half(tx_half), .tx_empty(tx_empty),
      .rx_pop(rx_pop), .tx_push(tx_push), .char_tmo(char_tmo),
      .timer_tick(timer_tick), .fifo_reset(fifo_reset),
      .flow_ctl_en(flow_ctl_en), .ext_fifo_en(ext_fifo_en),
      .swap_halves(swap_halves), .irq(irq));

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      step();
      bus_rd = 1'b0;
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      step();
      sig = 1'b0;
   endtask

   task automatic clean();
      logic [7:0] tmp;
      {rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty} = '0;
      step();
      rd(3'd2, tmp);
      wr(3'd1, 8'h00);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [4:0] p;
      int pulses;
      #1;
      chk("R1 irq in reset", {7'd0, irq}, 8'h00);
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1: reset state
      rd(3'd0, v); chk("R1 cfg", v, 8'h00);
      rd(3'd1, v); chk("R1 ien", v, 8'h00);
      rd(3'd2, v); chk("R1 status", v, 8'h3F);
      chk("R1 irq", {7'd0, irq}, 8'h00);
      chk("R1 fifo_reset", {7'd0, fifo_reset}, 8'h00);

      // R2: every configuration byte
      for (int d = 0; d < 256; d++) begin
         wr(3'd0, 8'(d));
         rd(3'd0, v);
         chk("R2 cfg readback", v, 8'(d) & 8'h1D);
         chk("R2 mode pins", {5'd0, flow_ctl_en, ext_fifo_en, swap_halves},
             {5'd0, 8'(d) >> 3 & 8'h1 ? 1'b1 : 1'b0, d[2] ? 1'b1 : 1'b0, d[0] ? 1'b1 : 1'b0});
      end
      // R3: every enable byte
      for (int d = 0; d < 256; d++) begin
         wr(3'd1, 8'(d));
         rd(3'd1, v);
         chk("R3 ien readback", v, 8'(d) & 8'h1F);
      end
      // R13: unused offsets
      for (int a = 3; a < 8; a++) begin
         rd(3'(a), v);
         chk("R13 unused offset", v, 8'h00);
      end
      clean();

      // R4: all 64 FIFO flag patterns, inverted into bits 5..0
      for (int f = 0; f < 64; f++) begin
         {rx_full, rx_half, rx_empty, tx_full, tx_half, tx_empty} = 6'(f);
         step();
         rd(3'd2, v);
         chk("R4 status flags", v, {2'b00, ~6'(f)});
      end
      clean();

      // R5: FIFO reset strobe and untouched registers
      wr(3'd0, 8'h15); wr(3'd1, 8'h0A);
      bus_addr = 3'd2; bus_wdata = 8'hFF; bus_wr = 1'b1;
      #1 chk("R5 strobe high", {7'd0, fifo_reset}, 8'h01);
      step(); bus_wr = 1'b0;
      #1 chk("R5 strobe one cycle", {7'd0, fifo_reset}, 8'h00);
      rd(3'd0, v); chk("R5 cfg kept", v, 8'h15);
      rd(3'd1, v); chk("R5 ien kept", v, 8'h0A);
      bus_addr = 3'd0; bus_wdata = 8'h15; bus_wr = 1'b1;
      #1 chk("R5 no strobe other offset", {7'd0, fifo_reset}, 8'h00);
      step(); bus_wr = 1'b0;
      clean();

      // R6: receive half-full follows the flag, level mode
      wr(3'd0, 8'h10); wr(3'd1, 8'h01);
      rx_half = 1'b1; #1 chk("R6 rx half irq", {7'd0, irq}, 8'h01);
      step(); chk("R6 rx half held", {7'd0, irq}, 8'h01);
      rx_half = 1'b0; #1 chk("R6 rx half gone", {7'd0, irq}, 8'h00);
      clean();

      // R7: character timeout
      pulse(char_tmo);
      rd(3'd2, v); chk("R7 set", v & 8'h40, 8'h40);
      rd(3'd2, v); chk("R7 cleared by status read", v & 8'h40, 8'h00);
      pulse(char_tmo);
      pulse(rx_pop);
      rd(3'd2, v); chk("R7 cleared by pop", v & 8'h40, 8'h00);
      char_tmo = 1'b1; rx_pop = 1'b1; step(); char_tmo = 1'b0; rx_pop = 1'b0;
      rd(3'd2, v); chk("R7 set wins", v & 8'h40, 8'h40);
      clean();

      // R8: transmit empty, level mode, enable bit2
      wr(3'd0, 8'h10); wr(3'd1, 8'h04);
      tx_empty = 1'b1; step();
      chk("R8 set on rise", {7'd0, irq}, 8'h01);
      pulse(tx_push); #1 chk("R8 cleared by push", {7'd0, irq}, 8'h00);
      step(); chk("R8 no reset while high", {7'd0, irq}, 8'h00);
      tx_empty = 1'b0; step(); tx_empty = 1'b1; step();
      chk("R8 set again", {7'd0, irq}, 8'h01);
      rd(3'd2, v); #1 chk("R8 cleared by status read", {7'd0, irq}, 8'h00);
      clean();

      // R9: transmit half-full, level mode, enable bit1
      wr(3'd0, 8'h10); wr(3'd1, 8'h02);
      tx_half = 1'b1; step();
      chk("R9 no set on rise", {7'd0, irq}, 8'h00);
      tx_half = 1'b0; step();
      chk("R9 set on fall", {7'd0, irq}, 8'h01);
      tx_half = 1'b1; step();
      chk("R9 cleared on refill", {7'd0, irq}, 8'h00);
      tx_half = 1'b0; step();
      chk("R9 set again", {7'd0, irq}, 8'h01);
      rd(3'd2, v); #1 chk("R9 cleared by status read", {7'd0, irq}, 8'h00);
      clean();

      // R10: timer pending survives reads and enabled writes
      pulse(timer_tick);
      rd(3'd2, v); chk("R10 set", v & 8'h80, 8'h80);
      rd(3'd2, v); chk("R10 kept on read", v & 8'h80, 8'h80);
      wr(3'd1, 8'h10);
      rd(3'd2, v); chk("R10 kept on enable", v & 8'h80, 8'h80);
      wr(3'd1, 8'hEF);
      rd(3'd2, v); chk("R10 cleared", v & 8'h80, 8'h00);
      clean();

      // R11: level request over enable words with timer enabled
      wr(3'd0, 8'h10); wr(3'd1, 8'h10);
      pulse(timer_tick); pulse(char_tmo);
      for (int rh = 0; rh < 2; rh++) begin
         rx_half = rh[0];
         for (int e = 16; e < 32; e++) begin
            wr(3'd1, 8'(e));
            p = {1'b1, 1'b1, 1'b0, 1'b0, rh[0]};
            chk("R11 level or", {7'd0, irq}, {7'd0, |(p & 5'(e))});
         end
      end
      clean();

      // R12: pulse mode
      wr(3'd0, 8'h00); wr(3'd1, 8'h01);
      rx_half = 1'b1; #1 chk("R12 pulse high", {7'd0, irq}, 8'h01);
      pulses = 0;
      for (int c = 0; c < 5; c++) begin
         step();
         if (irq) pulses++;
      end
      chk("R12 low while held", 8'(pulses), 8'h00);
      rx_half = 1'b0; step();
      rx_half = 1'b1; #1 chk("R12 pulse again", {7'd0, irq}, 8'h01);
      step(); chk("R12 pulse one cycle", {7'd0, irq}, 8'h00);
      clean();

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule